// File: doc/BRIEF.md
# MDIO Management Master

This block is a host-programmed master for the two-wire PHY management bus. It builds clause-22 read and write frames and sends them to external or on-chip PHYs. A host CPU reaches six 32-bit registers through a simple select/write/read port. The registers are configuration, command, target address, write data, read data and indicator. The block produces the management clock from the system clock through a programmable divider. It shifts each frame out MSB first: preamble, start, opcode, PHY address, register number and turnaround. It then drives the 16 data bits, or releases the line and samples them.

The two directions start in different ways. A write frame starts as a side effect of storing a value into the write-data register. A read frame starts only when the read bit of the command register changes from 0 to 1. The host follows progress through two flags in the indicator register: a busy flag that covers every frame, and a not-valid flag that covers the time until read data has been captured. Writing the configuration register with its reset bit set abandons the current frame at once.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The target-address register (select 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0. Every other bit reads back as 0.
- R2: Writing select 3 while idle starts a write frame. MDIO carries 32 ones, then 01, then opcode 01, then PHY address and register number MSB first, then 10, then the 16 data bits MSB first. mdio_oe stays high for all 64 bits.
- R3: A read frame starts only when a write to select 1 changes bit 0 from 0 to 1. Writing 1 while the stored bit is already 1 starts nothing.
- R4: A read frame sends 32 ones, 01, opcode 10 and the two addresses. mdio_oe is low for the last 18 bit times. The 16 bits sampled at the last 16 MDC rising edges appear MSB first in bits 15:0 of select 4.
- R5: Indicator bit 0 (busy) is 1 from the cycle after a frame starts until the frame ends. A frame lasts exactly 64 MDC periods.
- R6: Indicator bit 1 (not-valid) is set when a read starts and is cleared on the edge that loads select 4. It never rises during a write frame.
- R7: The MDC period is 2*(N+1) system clocks, where N is configuration bits 2:0. MDC is low whenever no frame runs. mdio_o changes only when MDC falls.
- R8: A configuration write with bit 31 set aborts any frame. Busy and not-valid then read 0, MDC and mdio_oe are low, the divider returns to 7, and the next frame runs normally.
- R9: While busy is set, writes to select 3 and read triggers on select 1 are ignored. The running frame and the stored write data are unchanged, and no extra frame follows.
- R10: After reset the indicator reads 0, MDC and mdio_oe are low, and the configuration register reads 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select (0 config, 1 command, 2 address, 3 write data, 4 read data, 5 indicator) |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Drive enable for the data pin |
| mdio_i | input | 1 | Serial data from the PHY |

## Verification
The bench attacks the read trigger's edge rule. A design that fired on the level of the command bit would launch a second read when 1 is rewritten. The bench writes the data and command registers in the middle of a frame; a design that did not gate them would corrupt the data field or append a frame, which shows up as a longer busy time. It aborts a read part-way through. A design that left not-valid set, or left MDC high, would be visible on the very next cycle. It also sweeps the divider from 0 to 7, so a period off by one half-cycle, or data launched on the wrong MDC edge, changes the measured spacing or the bits captured at the rising edges.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_IDX    = FRAME_LEN - DATA_W - 2;
    localparam int DATA_IDX  = FRAME_LEN - DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam int CFG_ABORT_BIT = 31;
    localparam int CMD_READ_BIT  = 0;
    localparam int ADDR_PHY_LSB  = 8;
    localparam int IND_BUSY_BIT  = 0;
    localparam int IND_NV_BIT    = 1;

    typedef enum logic [2:0] {
        SEL_CFG   = 3'd0,
        SEL_CMD   = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_WDATA = 3'd3,
        SEL_RDATA = 3'd4,
        SEL_IND   = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } mdio_req_t;

    // Whole serial frame, first bit on the wire in the MSB.
    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_req_t r);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] payload;
        op      = r.is_read ? OP_READ : OP_WRITE;
        ta      = r.is_read ? 2'b11 : 2'b10;
        payload = r.is_read ? '0 : r.data;
        return {{PRE_LEN{1'b1}}, 2'b01, op, r.phy, r.regn, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    assign tick      = run && (cnt_q == div);
    assign rise_tick = tick && !mdc_q;
    assign fall_tick = tick && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);  // R7

    AST_MDC_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        run && !rise_tick && !fall_tick |=> $stable(mdc));  // R7

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic [DIV_W-1:0]  div,
    input  logic              mdio_i,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic                 busy_q;
    logic                 rd_q;
    logic [IDX_W-1:0]     idx_q;
    logic [FRAME_LEN-1:0] sh_q;
    logic [DATA_W-1:0]    cap_q;
    logic                 rise_tick;
    logic                 fall_tick;
    logic                 last_bit;

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_q),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
    assign finish   = busy_q && fall_tick && last_bit;
    assign busy     = busy_q;
    assign rd_data  = cap_q;
    assign mdio_o   = busy_q && sh_q[FRAME_LEN-1];
    assign mdio_oe  = busy_q && (!rd_q || (idx_q < IDX_W'(TA_IDX)));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            idx_q  <= '0;
            sh_q   <= '0;
            if (rst) cap_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                rd_q   <= req.is_read;
                idx_q  <= '0;
                sh_q   <= build_frame(req);
            end
        end else begin
            if (rise_tick && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                if (last_bit) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= sh_q << 1;
                end
            end
        end
    end

    AST_FRAME_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) && !$past(abort) && !$past(rst)
            |-> $past(idx_q) == IDX_W'(FRAME_LEN - 1));  // R5

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        busy_q && $past(busy_q) && mdc && $past(mdc) |-> $stable(mdio_o));  // R7

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W     = 3,
    parameter logic [DIV_W-1:0] DIV_RESET = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              finish,
    input  logic [DATA_W-1:0] rd_data,
    output logic [31:0]       rdata,
    output logic              start,
    output mdio_req_t         req,
    output logic              abort,
    output logic [DIV_W-1:0]  div,
    output logic              nv
);
    logic [DIV_W-1:0]  div_q;
    logic              cmd_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] regn_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] st_q;
    logic              nv_q;
    logic              wr_cfg, wr_cmd, wr_addr, wr_wd;
    logic              start_wr, start_rd;
    logic              unused_wdata_bits;

    assign wr_cfg  = wr && (sel == SEL_CFG);
    assign wr_cmd  = wr && (sel == SEL_CMD);
    assign wr_addr = wr && (sel == SEL_ADDR);
    assign wr_wd   = wr && (sel == SEL_WDATA);

    assign abort    = wr_cfg && wdata[CFG_ABORT_BIT];
    assign start_wr = wr_wd && !busy;
    assign start_rd = wr_cmd && wdata[CMD_READ_BIT] && !cmd_q && !busy;
    assign start    = start_wr || start_rd;
    assign div      = div_q;
    assign nv       = nv_q;

    assign unused_wdata_bits = ^wdata[30:16];

    always_comb begin
        req.is_read = start_rd;
        req.phy     = phy_q;
        req.regn    = regn_q;
        req.data    = wdata[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_RESET;
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
            wd_q   <= '0;
            st_q   <= '0;
            nv_q   <= 1'b0;
        end else begin
            if (wr_cfg)
                div_q <= abort ? DIV_RESET : wdata[DIV_W-1:0];
            if (wr_cmd)
                cmd_q <= wdata[CMD_READ_BIT];
            if (wr_addr) begin
                phy_q  <= wdata[ADDR_PHY_LSB +: ADDR_W];
                regn_q <= wdata[ADDR_W-1:0];
            end
            if (start_wr)
                wd_q <= wdata[DATA_W-1:0];
            if (abort) begin
                nv_q <= 1'b0;
            end else if (start_rd) begin
                nv_q <= 1'b1;
            end else if (finish && nv_q) begin
                st_q <= rd_data;
                nv_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CFG:   rdata = 32'(div_q);
            SEL_CMD:   rdata = 32'(cmd_q);
            SEL_ADDR:  rdata = (32'(phy_q) << ADDR_PHY_LSB) | 32'(regn_q);
            SEL_WDATA: rdata = 32'(wd_q);
            SEL_RDATA: rdata = 32'(st_q);
            SEL_IND: begin
                rdata[IND_BUSY_BIT] = busy;
                rdata[IND_NV_BIT]   = nv_q;
            end
            default:   rdata = '0;
        endcase
    end

    AST_NV_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
        nv_q |-> busy);  // R6

    AST_WDATA_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy && wr_wd |=> $stable(wd_q));  // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy && !nv_q);  // R8

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W     = 3,
    parameter logic [DIV_W-1:0] DIV_RESET = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [2:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy;
    logic              finish;
    logic [DATA_W-1:0] rd_data;
    logic              start;
    mdio_req_t         req;
    logic              abort;
    logic [DIV_W-1:0]  div;
    logic              nv;

    mdio_host_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (host_wr),
        .sel     (host_sel),
        .wdata   (host_wdata),
        .busy    (busy),
        .finish  (finish),
        .rd_data (rd_data),
        .rdata   (host_rdata),
        .start   (start),
        .req     (req),
        .abort   (abort),
        .div     (div),
        .nv      (nv)
    );

    mdio_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .abort   (abort),
        .start   (start),
        .req     (req),
        .div     (div),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .finish  (finish),
        .rd_data (rd_data),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        busy && !nv |-> mdio_oe);  // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);  // R10

endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;

    localparam int NVEC = 6;
    // {is_read, divider, phy, register, data}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 5'h01, 5'h00, 16'h1234},
        {1'b1, 3'd1, 5'h1F, 5'h1F, 16'hA5C3},
        {1'b0, 3'd3, 5'h10, 5'h0A, 16'hFFFF},
        {1'b1, 3'd0, 5'h00, 5'h01, 16'h8001},
        {1'b0, 3'd2, 5'h15, 5'h0A, 16'h0000},
        {1'b1, 3'd7, 5'h0A, 5'h15, 16'h7FFE}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rc = 0;
    int hi_change = 0;
    int last_rise = 0;
    int prev_rise = 0;
    logic mdc_prev = 1'b0;
    logic o_prev = 1'b0;
    logic [15:0] phy_word = '0;
    logic cap_o [64];
    logic cap_oe [64];

    always #5 clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i)
    );

    // Line monitor and PHY model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_prev) begin
            if (rc < 64) begin
                cap_o[rc]  = mdio_o;
                cap_oe[rc] = mdio_oe;
            end
            rc++;
            prev_rise = last_rise;
            last_rise = cyc;
        end
        if (mdc && mdc_prev && (mdio_o !== o_prev)) hi_change++;
        if (!mdc && mdc_prev) begin
            if (rc >= 48 && rc < 64) mdio_i = phy_word[63 - rc];
            else mdio_i = 1'b0;
        end
        mdc_prev = mdc;
        o_prev   = mdio_o;
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL WDOG: actual %0d cycles expected below 100000", cyc);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] s, input logic [31:0] d);
        host_sel   = s;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] s, output logic [31:0] d);
        host_sel = s;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(output int busy_cnt, output bit saw_nv);
        logic [31:0] r;
        busy_cnt = 0;
        saw_nv   = 1'b0;
        host_read(3'd5, r);
        while (r[0] && busy_cnt < 5000) begin
            busy_cnt++;
            if (r[1]) saw_nv = 1'b1;
            @(negedge clk);
            host_read(3'd5, r);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic exp_bit(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] dat, input int k);
        if (k < 32) return 1'b1;
        if (k == 32) return 1'b0;
        if (k == 33) return 1'b1;
        if (k == 34) return rd;
        if (k == 35) return !rd;
        if (k < 41) return phy[40 - k];
        if (k < 46) return rg[45 - k];
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        return dat[63 - k];
    endfunction

    initial begin
        logic [31:0] r;
        int          bc;
        bit          snv;
        idle_cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        host_read(3'd5, r);
        check(r == 32'h0, "R10 indicator", r, 32'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);
        host_read(3'd0, r);
        check(r == 32'h7, "R10 config", r, 32'h7);

        // R1: address field positions
        host_write(3'd2, 32'hFFFF_FFFF);
        host_read(3'd2, r);
        check(r == 32'h0000_1F1F, "R1 all ones", r, 32'h0000_1F1F);
        host_write(3'd2, 32'h0000_1234);
        host_read(3'd2, r);
        check(r == 32'h0000_1214, "R1 pattern", r, 32'h0000_1214);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic        rd;
            logic [2:0]  dv;
            logic [4:0]  phy, rg;
            logic [15:0] dat;
            int          bad_o, bad_oe;
            {rd, dv, phy, rg, dat} = VEC[i];
            host_write(3'd0, {29'h0, dv});
            host_write(3'd2, {19'h0, phy, 3'h0, rg});
            rc = 0;
            hi_change = 0;
            phy_word = dat;
            if (rd) begin
                host_write(3'd1, 32'h0);
                host_write(3'd1, 32'h1);
            end else begin
                host_write(3'd3, {16'h0, dat});
            end
            wait_idle(bc, snv);
            check(bc == 128 * (dv + 1), "R5 busy length", bc, 128 * (dv + 1));
            check(rc == 64, "R5 mdc periods", rc, 64);
            check(last_rise - prev_rise == 2 * (dv + 1), "R7 mdc period",
                  last_rise - prev_rise, 2 * (dv + 1));
            check(hi_change == 0, "R7 change while mdc high", hi_change, 0);
            check(mdc == 1'b0, "R7 mdc idle low", {31'h0, mdc}, 32'h0);
            bad_o = 0;
            bad_oe = 0;
            for (int k = 0; k < 64; k++) begin
                logic eoe;
                eoe = !rd || (k < 46);
                if (cap_oe[k] !== eoe) bad_oe++;
                if (eoe && cap_o[k] !== exp_bit(rd, phy, rg, dat, k)) bad_o++;
            end
            check(bad_o == 0, rd ? "R4 read frame bits" : "R2 write frame bits", bad_o, 0);
            check(bad_oe == 0, rd ? "R4 oe release" : "R2 oe held", bad_oe, 0);
            check(snv == rd, "R6 not-valid during frame", {31'h0, snv}, {31'h0, rd});
            host_read(3'd5, r);
            check(r == 32'h0, "R6 flags clear at end", r, 32'h0);
            if (rd) begin
                host_read(3'd4, r);
                check(r == {16'h0, dat}, "R4 status data", r, {16'h0, dat});
            end
        end

        // R3: rewriting 1 with the bit already set starts nothing
        host_write(3'd1, 32'h1);
        idle_cycles(4);
        host_read(3'd5, r);
        check(r == 32'h0, "R3 no level trigger", r, 32'h0);
        check(rc == 64, "R3 no mdc activity", rc, 64);

        // R9: writes while busy are ignored
        host_write(3'd0, 32'h0);
        host_write(3'd2, 32'h0000_0102);
        rc = 0;
        phy_word = 16'h0;
        host_write(3'd3, 32'h0000_C0DE);
        host_write(3'd3, 32'h0000_BEEF);
        host_write(3'd1, 32'h0);
        host_write(3'd1, 32'h1);
        wait_idle(bc, snv);
        check(bc == 128 - 3, "R9 single frame length", bc, 125);
        begin
            logic [15:0] got;
            for (int k = 0; k < 16; k++) got[15 - k] = cap_o[48 + k];
            check(got == 16'hC0DE, "R9 data unchanged", {16'h0, got}, 32'h0000_C0DE);
        end
        check(snv == 1'b0, "R9 no read started", {31'h0, snv}, 32'h0);
        idle_cycles(4);
        host_read(3'd5, r);
        check(r == 32'h0, "R9 no follow-on frame", r, 32'h0);
        host_read(3'd3, r);
        check(r == 32'h0000_C0DE, "R9 stored write data", r, 32'h0000_C0DE);

        // R8: abort a read part-way
        host_write(3'd0, 32'h1);
        host_write(3'd1, 32'h0);
        host_write(3'd1, 32'h1);
        idle_cycles(40);
        host_read(3'd5, r);
        check(r == 32'h3, "R8 read in flight", r, 32'h3);
        host_write(3'd0, 32'h8000_0000);
        @(negedge clk);
        host_read(3'd5, r);
        check(r == 32'h0, "R8 flags after abort", r, 32'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 lines after abort", {30'h0, mdc, mdio_oe}, 32'h0);
        host_read(3'd0, r);
        check(r == 32'h7, "R8 divider restored", r, 32'h7);
        host_write(3'd0, 32'h0);
        rc = 0;
        host_write(3'd3, 32'h0000_5555);
        wait_idle(bc, snv);
        check(bc == 128 && rc == 64, "R8 next frame normal", bc, 128);

        summary_and_end();
    end

endmodule